// File: doc/BRIEF.md
# Retirement head commit controller

This block decides, every cycle, the fate of the oldest instruction of one thread: the entry at the head of the reorder buffer. It looks at the head's status flags, at the head's position in this cycle's commit group, and at whether older stores are still waiting to write back. From these it chooses one of four actions:

- retire the head;
- hand an unexecuted non-speculative head back to the execute stage;
- request a replay of an uncacheable load;
- raise a trap for a faulting head.

The head arrives as a valid/ready stream. The buffer presents an entry with `hd_vld`, and the block raises `hd_rdy` in the same cycle when it retires that entry. The transfer is the cycle in which both are high, and the buffer advances its head at that clock edge. While `hd_rdy` is low, the buffer must hold the entry steady. A low `hd_rdy` is also the commit-success bit the surrounding commit loop uses to stop at the first head that does not commit.

All decision outputs are combinational in the current head and the current thread status, so each one lasts exactly the cycle in which the buffer presents the matching head. The buffer reacts to a can-commit clear at the same edge, so the pulse does not repeat. Only the thread status and the non-speculative stall counter are registered.

Top module: `commit_head_ctl`

## Requirements
- R1: An executed, non-faulting head with `hd_vld` and `hd_can_commit` high retires in that cycle (`hd_rdy`=1), whatever its slot or pending stores. `mark_done` pulses with it unless the head is a store. `st_commit` pulses with it only if the head is a store.
- R2: On retirement, each destination slot i with `hd_dst_vld[i]`=1 pulses `rm_we[i]` and drives its architectural index on `rm_arch[i*AREG_W +: AREG_W]` and its physical index on `rm_phys[i*PREG_W +: PREG_W]`. Without retirement `rm_we` is 0.
- R3: An unexecuted head flagged non-speculative, store-conditional, memory barrier or write barrier never retires. When `grp_slot`≠0 or `st_wb_pend`=1 it waits, and every output pulse stays 0.
- R4: Such a head at `grp_slot`=0 with no pending stores drives `ns_vld`=1 and `ns_seq`=`hd_seq`, and pulses `clr_cc`. `stall_cnt` rises by one at the next edge and saturates at all ones. The special flags take priority over `hd_load`.
- R5: An unexecuted load with `hd_uncache`=1, at slot 0 with no pending stores, drives `ns_vld`, `ns_seq`=`hd_seq`, `ld_replay` and `clr_cc`. `stall_cnt` is unchanged. Under any other slot, or with stores pending, it waits with no pulses.
- R6: An unexecuted load with `hd_uncache`=0, or an unexecuted head with none of the special or load flags, pulses `head_err` and nothing else.
- R7: An executed head with `hd_fault`=1 waits with no pulses while `grp_slot`≠0 or `st_wb_pend`=1. Otherwise it pulses `mark_done`, `trap_req` and `trap_squash`, does not retire, and `thr_status` becomes 1 (trap pending) at the next edge.
- R8: While `thr_status`=1 no head is acted on and every pulse stays 0. `trap_done`=1 in that state returns `thr_status` to 0 (running) at the next edge. `trap_done` has no effect while running.
- R9: With `hd_vld`=0 or `hd_can_commit`=0 every output pulse is 0.
- R10: After reset `thr_status`=0 and `stall_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_vld | input | 1 | Head entry present |
| hd_rdy | output | 1 | Head retired this cycle (commit success) |
| hd_can_commit | input | 1 | Head is eligible for a commit attempt |
| hd_exec | input | 1 | Head has executed |
| hd_fault | input | 1 | Head carries a fault |
| hd_store | input | 1 | Head is a store |
| hd_load | input | 1 | Head is a load |
| hd_uncache | input | 1 | Head load targets uncacheable memory |
| hd_nonspec | input | 1 | Head must run non-speculatively |
| hd_sc | input | 1 | Head is a store-conditional |
| hd_mbar | input | 1 | Head is a memory barrier |
| hd_wbar | input | 1 | Head is a write barrier |
| hd_seq | input | SEQ_W | Head sequence number |
| hd_dst_vld | input | NDEST | Destination slot valid bits |
| hd_dst_arch | input | NDEST*AREG_W | Architectural destination indices |
| hd_dst_phys | input | NDEST*PREG_W | Physical destination indices |
| grp_slot | input | SLOT_W | Head position in this cycle's commit group |
| st_wb_pend | input | 1 | Stores still waiting to write back |
| trap_done | input | 1 | Trap handling finished |
| ns_vld | output | 1 | Sequence number sent back to execute |
| ns_seq | output | SEQ_W | Sequence number sent back |
| ld_replay | output | 1 | Uncached load replay request |
| clr_cc | output | 1 | Clear the head's can-commit bit |
| mark_done | output | 1 | Mark the head completed |
| st_commit | output | 1 | A store committed this cycle |
| trap_req | output | 1 | Trap request |
| trap_squash | output | 1 | Trap squash event |
| head_err | output | 1 | Unexecuted head of an unsupported kind |
| rm_we | output | NDEST | Committed rename map write enables |
| rm_arch | output | NDEST*AREG_W | Rename map write architectural indices |
| rm_phys | output | NDEST*PREG_W | Rename map write physical indices |
| stall_cnt | output | CNT_W | Saturating non-speculative stall count |
| thr_status | output | 2 | Thread status: 0 running, 1 trap pending |

## Verification
The bench builds the block with CNT_W=3 so that nine non-speculative hand-backs drive the stall counter into saturation. It uses SLOT_W=2 so that non-zero group slots 1 to 3 exercise the leading-slot gate. It keeps NDEST=2 so that single- and dual-destination retirements both occur. SEQ_W=8, AREG_W=5 and PREG_W=6 keep the sequence numbers and register indices distinct, so a swapped rename map lane shows up.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [2:0] {
    A_NONE, A_WAIT, A_RETIRE, A_NONSPEC, A_UNCLD, A_TRAP, A_ERR
  } act_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TRAP = 2'd1
  } cstat_e;

  typedef struct packed {
    logic execd;
    logic fault;
    logic store;
    logic load;
    logic uncache;
    logic nonspec;
    logic sc;
    logic mbar;
    logic wbar;
  } hflags_t;
endpackage

// File: rtl/cmt_decode.sv
module cmt_decode
  import cmt_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic              vld,
  input  logic              can_commit,
  input  logic              running,
  input  hflags_t           fl,
  input  logic [SLOT_W-1:0] slot,
  input  logic              st_pend,
  output act_e              act
);
  logic lead;
  logic special;

  // Side effects are allowed only for the leading slot with no stores in flight.
  assign lead    = (slot == '0) && !st_pend;
  assign special = fl.nonspec | fl.sc | fl.mbar | fl.wbar;

  always_comb begin
    act = A_NONE;
    if (vld && can_commit && running) begin
      if (!fl.execd) begin
        if (special)
          act = lead ? A_NONSPEC : A_WAIT;
        else if (fl.load)
          act = !fl.uncache ? A_ERR : (lead ? A_UNCLD : A_WAIT);
        else
          act = A_ERR;
      end else if (fl.fault) begin
        act = lead ? A_TRAP : A_WAIT;
      end else begin
        act = A_RETIRE;
      end
    end
  end
endmodule

// File: rtl/cmt_state.sv
module cmt_state
  import cmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  input  logic             trap_done,
  output cstat_e           status,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= ST_RUN;
    end else begin
      unique case (status)
        ST_RUN:  if (act == A_TRAP) status <= ST_TRAP;
        ST_TRAP: if (trap_done)     status <= ST_RUN;
        default: status <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (act == A_NONSPEC && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmt_rmap_wr.sv
module cmt_rmap_wr #(
  parameter int NDEST  = 2,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6
) (
  input  logic                     fire,
  input  logic [NDEST-1:0]         dst_vld,
  input  logic [NDEST*AREG_W-1:0]  dst_arch,
  input  logic [NDEST*PREG_W-1:0]  dst_phys,
  output logic [NDEST-1:0]         we,
  output logic [NDEST*AREG_W-1:0]  arch,
  output logic [NDEST*PREG_W-1:0]  phys
);
  for (genvar i = 0; i < NDEST; i++) begin : g_lane
    assign we[i] = fire & dst_vld[i];
    assign arch[i*AREG_W +: AREG_W] = we[i] ? dst_arch[i*AREG_W +: AREG_W] : '0;
    assign phys[i*PREG_W +: PREG_W] = we[i] ? dst_phys[i*PREG_W +: PREG_W] : '0;
  end
endmodule

// File: rtl/commit_head_ctl.sv
module commit_head_ctl
  import cmt_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int NDEST  = 2,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hd_vld,
  output logic                    hd_rdy,
  input  logic                    hd_can_commit,
  input  logic                    hd_exec,
  input  logic                    hd_fault,
  input  logic                    hd_store,
  input  logic                    hd_load,
  input  logic                    hd_uncache,
  input  logic                    hd_nonspec,
  input  logic                    hd_sc,
  input  logic                    hd_mbar,
  input  logic                    hd_wbar,
  input  logic [SEQ_W-1:0]        hd_seq,
  input  logic [NDEST-1:0]        hd_dst_vld,
  input  logic [NDEST*AREG_W-1:0] hd_dst_arch,
  input  logic [NDEST*PREG_W-1:0] hd_dst_phys,
  input  logic [SLOT_W-1:0]       grp_slot,
  input  logic                    st_wb_pend,
  input  logic                    trap_done,
  output logic                    ns_vld,
  output logic [SEQ_W-1:0]        ns_seq,
  output logic                    ld_replay,
  output logic                    clr_cc,
  output logic                    mark_done,
  output logic                    st_commit,
  output logic                    trap_req,
  output logic                    trap_squash,
  output logic                    head_err,
  output logic [NDEST-1:0]        rm_we,
  output logic [NDEST*AREG_W-1:0] rm_arch,
  output logic [NDEST*PREG_W-1:0] rm_phys,
  output logic [CNT_W-1:0]        stall_cnt,
  output logic [1:0]              thr_status
);
  hflags_t fl;
  act_e    act;
  cstat_e  status;
  logic    retire;
  logic    sendback;

  assign fl = '{execd: hd_exec, fault: hd_fault, store: hd_store, load: hd_load,
                uncache: hd_uncache, nonspec: hd_nonspec, sc: hd_sc,
                mbar: hd_mbar, wbar: hd_wbar};

  cmt_decode #(.SLOT_W(SLOT_W)) u_dec (
    .vld        (hd_vld),
    .can_commit (hd_can_commit),
    .running    (status == ST_RUN),
    .fl         (fl),
    .slot       (grp_slot),
    .st_pend    (st_wb_pend),
    .act        (act)
  );

  cmt_state #(.CNT_W(CNT_W)) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .trap_done (trap_done),
    .status    (status),
    .cnt       (stall_cnt)
  );

  assign retire   = (act == A_RETIRE);
  assign sendback = (act == A_NONSPEC) || (act == A_UNCLD);

  cmt_rmap_wr #(.NDEST(NDEST), .AREG_W(AREG_W), .PREG_W(PREG_W)) u_rm (
    .fire     (retire),
    .dst_vld  (hd_dst_vld),
    .dst_arch (hd_dst_arch),
    .dst_phys (hd_dst_phys),
    .we       (rm_we),
    .arch     (rm_arch),
    .phys     (rm_phys)
  );

  assign hd_rdy      = retire;
  assign ns_vld      = sendback;
  assign ns_seq      = sendback ? hd_seq : '0;
  assign ld_replay   = (act == A_UNCLD);
  assign clr_cc      = sendback;
  assign mark_done   = (retire && !hd_store) || (act == A_TRAP);
  assign st_commit   = retire && hd_store;
  assign trap_req    = (act == A_TRAP);
  assign trap_squash = (act == A_TRAP);
  assign head_err    = (act == A_ERR);
  assign thr_status  = status;
endmodule

// File: rtl/cmt_head_chk.sv
module cmt_head_chk #(
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 16,
  parameter int NDEST  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hd_rdy,
  input logic              ns_vld,
  input logic              ld_replay,
  input logic              trap_req,
  input logic              head_err,
  input logic [NDEST-1:0]  rm_we,
  input logic [SLOT_W-1:0] grp_slot,
  input logic              st_wb_pend,
  input logic [CNT_W-1:0]  stall_cnt,
  input logic [1:0]        thr_status
);
  // R1
  retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_rdy |-> !trap_req && !ns_vld && !head_err);
  // R2
  rmap_only_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_we != '0) |-> hd_rdy);
  // R3
  sendback_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_vld |-> (grp_slot == '0) && !st_wb_pend);
  // R4
  stall_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_vld && !ld_replay && stall_cnt != '1) |=> stall_cnt == $past(stall_cnt) + 1'b1);
  // R7
  trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (grp_slot == '0) && !st_wb_pend);
  // R7
  trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> thr_status == 2'd1);
  // R8
  pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_status == 2'd1) |-> !hd_rdy && !trap_req && !ns_vld && !head_err);
endmodule

bind commit_head_ctl cmt_head_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .NDEST(NDEST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hd_rdy     (hd_rdy),
  .ns_vld     (ns_vld),
  .ld_replay  (ld_replay),
  .trap_req   (trap_req),
  .head_err   (head_err),
  .rm_we      (rm_we),
  .grp_slot   (grp_slot),
  .st_wb_pend (st_wb_pend),
  .stall_cnt  (stall_cnt),
  .thr_status (thr_status)
);

// File: tb/sim_commit_head_ctl.sv
module sim_commit_head_ctl;
  localparam int SEQ_W = 8, AREG_W = 5, PREG_W = 6, NDEST = 2, SLOT_W = 2, CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic hd_vld, hd_rdy, hd_can_commit, hd_exec, hd_fault, hd_store, hd_load;
  logic hd_uncache, hd_nonspec, hd_sc, hd_mbar, hd_wbar;
  logic [SEQ_W-1:0] hd_seq, ns_seq;
  logic [NDEST-1:0] hd_dst_vld, rm_we;
  logic [NDEST*AREG_W-1:0] hd_dst_arch, rm_arch;
  logic [NDEST*PREG_W-1:0] hd_dst_phys, rm_phys;
  logic [SLOT_W-1:0] grp_slot;
  logic st_wb_pend, trap_done;
  logic ns_vld, ld_replay, clr_cc, mark_done, st_commit, trap_req, trap_squash, head_err;
  logic [CNT_W-1:0] stall_cnt;
  logic [1:0] thr_status;

  commit_head_ctl #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .NDEST(NDEST),
                    .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u0 (.*);

  typedef struct {
    logic vld, cc, ex, flt, st, ld, unc, ns, sc, mb, wb;
    logic [SEQ_W-1:0] seq;
    logic [NDEST-1:0] dv;
    logic [NDEST*AREG_W-1:0] da;
    logic [NDEST*PREG_W-1:0] dp;
    logic [SLOT_W-1:0] slot;
    logic pend, tdone;
  } stim_t;

  typedef struct {
    string req;
    logic rdy, nsv, rep, clr, done, stc, trap, err;
    logic [SEQ_W-1:0] nss;
    logic [NDEST-1:0] we;
    logic [NDEST*AREG_W-1:0] ar;
    logic [NDEST*PREG_W-1:0] ph;
    logic [CNT_W-1:0] cnt;
    logic [1:0] stat;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [1:0] m_stat = 2'd0;
  logic [CNT_W-1:0] m_cnt = '0;

  function automatic stim_t blank();
    stim_t s;
    s = '{vld:1'b1, cc:1'b1, ex:1'b0, flt:1'b0, st:1'b0, ld:1'b0, unc:1'b0, ns:1'b0,
          sc:1'b0, mb:1'b0, wb:1'b0, seq:'0, dv:'0, da:'0, dp:'0, slot:'0,
          pend:1'b0, tdone:1'b0};
    return s;
  endfunction

  // Expected outputs from the requirement text; updates the bench's own status/counter model.
  function automatic exp_t model(stim_t s, string req);
    exp_t e;
    logic lead, spec;
    e = '{req:req, rdy:0, nsv:0, rep:0, clr:0, done:0, stc:0, trap:0, err:0,
          nss:'0, we:'0, ar:'0, ph:'0, cnt:m_cnt, stat:m_stat};
    lead = (s.slot == 0) && !s.pend;
    spec = s.ns | s.sc | s.mb | s.wb;
    if (m_stat == 2'd1) begin
      if (s.tdone) m_stat = 2'd0;
    end else if (s.vld && s.cc) begin
      if (!s.ex) begin
        if (spec) begin
          if (lead) begin
            e.nsv = 1; e.nss = s.seq; e.clr = 1;
            if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
          end
        end else if (s.ld && s.unc) begin
          if (lead) begin e.nsv = 1; e.nss = s.seq; e.clr = 1; e.rep = 1; end
        end else e.err = 1;
      end else if (s.flt) begin
        if (lead) begin e.done = 1; e.trap = 1; m_stat = 2'd1; end
      end else begin
        e.rdy = 1; e.done = !s.st; e.stc = s.st;
        for (int i = 0; i < NDEST; i++)
          if (s.dv[i]) begin
            e.we[i] = 1'b1;
            e.ar[i*AREG_W +: AREG_W] = s.da[i*AREG_W +: AREG_W];
            e.ph[i*PREG_W +: PREG_W] = s.dp[i*PREG_W +: PREG_W];
          end
      end
    end
    return e;
  endfunction

  task automatic drive(stim_t s, string req);
    @(negedge clk);
    hd_vld = s.vld; hd_can_commit = s.cc; hd_exec = s.ex; hd_fault = s.flt;
    hd_store = s.st; hd_load = s.ld; hd_uncache = s.unc; hd_nonspec = s.ns;
    hd_sc = s.sc; hd_mbar = s.mb; hd_wbar = s.wb; hd_seq = s.seq;
    hd_dst_vld = s.dv; hd_dst_arch = s.da; hd_dst_phys = s.dp;
    grp_slot = s.slot; st_wb_pend = s.pend; trap_done = s.tdone;
    q.push_back(model(s, req));
  endtask

  // Monitor: compares each expected item with the outputs settled after the drive.
  initial begin
    forever begin
      @(negedge clk); #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({hd_rdy, ns_vld, ld_replay, clr_cc, mark_done, st_commit, trap_req, trap_squash, head_err}
              !== {e.rdy, e.nsv, e.rep, e.clr, e.done, e.stc, e.trap, e.trap, e.err} ||
            ns_seq !== e.nss || rm_we !== e.we || rm_arch !== e.ar || rm_phys !== e.ph ||
            stall_cnt !== e.cnt || thr_status !== e.stat) begin
          errors++;
          $display("FAIL %s: act rdy%b nsv%b rep%b clr%b done%b stc%b trap%b sq%b err%b seq%h we%b ar%h ph%h cnt%0d st%0d | exp rdy%b nsv%b rep%b clr%b done%b stc%b trap%b sq%b err%b seq%h we%b ar%h ph%h cnt%0d st%0d",
            e.req, hd_rdy, ns_vld, ld_replay, clr_cc, mark_done, st_commit, trap_req, trap_squash,
            head_err, ns_seq, rm_we, rm_arch, rm_phys, stall_cnt, thr_status,
            e.rdy, e.nsv, e.rep, e.clr, e.done, e.stc, e.trap, e.trap, e.err, e.nss, e.we,
            e.ar, e.ph, e.cnt, e.stat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    s = blank(); s.vld = 0;
    hd_vld = 0; hd_can_commit = 0; hd_exec = 0; hd_fault = 0; hd_store = 0; hd_load = 0;
    hd_uncache = 0; hd_nonspec = 0; hd_sc = 0; hd_mbar = 0; hd_wbar = 0; hd_seq = '0;
    hd_dst_vld = '0; hd_dst_arch = '0; hd_dst_phys = '0; grp_slot = '0;
    st_wb_pend = 0; trap_done = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    checks++;
    if (thr_status !== 2'd0 || stall_cnt !== '0) begin
      errors++;
      $display("FAIL R10: act st%0d cnt%0d exp st0 cnt0", thr_status, stall_cnt);
    end
    rst_n = 1;

    drive(s, "R9 no head");
    s = blank(); s.ex = 1; s.cc = 0; drive(s, "R9 can-commit low");
    // R1/R2: plain retire with two destinations, ignores slot and pending stores
    s = blank(); s.ex = 1; s.seq = 8'h21; s.dv = 2'b11; s.da = {5'd7, 5'd3}; s.dp = {6'd40, 6'd12};
    s.slot = 3; s.pend = 1; drive(s, "R1 R2 retire two dests");
    s = blank(); s.ex = 1; s.st = 1; s.dv = 2'b10; s.da = {5'd9, 5'd1}; s.dp = {6'd33, 6'd2};
    drive(s, "R1 R2 store retire lane1");
    // R3: special head waits
    s = blank(); s.ns = 1; s.seq = 8'h30; s.slot = 1; drive(s, "R3 wait slot");
    s = blank(); s.mb = 1; s.seq = 8'h31; s.pend = 1; drive(s, "R3 wait pend");
    // R4: each special kind sends back; load flag is overridden
    s = blank(); s.ns = 1; s.seq = 8'h40; drive(s, "R4 nonspec");
    s = blank(); s.sc = 1; s.seq = 8'h41; drive(s, "R4 store-cond");
    s = blank(); s.mb = 1; s.seq = 8'h42; drive(s, "R4 mem barrier");
    s = blank(); s.wb = 1; s.ld = 1; s.seq = 8'h43; drive(s, "R4 write barrier over load");
    for (int i = 0; i < 5; i++) begin
      s = blank(); s.ns = 1; s.seq = 8'h50 + 8'(i); drive(s, "R4 saturate");
    end
    // R5: uncached load
    s = blank(); s.ld = 1; s.unc = 1; s.seq = 8'h60; s.slot = 2; drive(s, "R5 wait");
    s = blank(); s.ld = 1; s.unc = 1; s.seq = 8'h61; drive(s, "R5 replay");
    // R6: error cases
    s = blank(); s.ld = 1; s.seq = 8'h70; drive(s, "R6 cacheable load");
    s = blank(); s.seq = 8'h71; s.slot = 1; drive(s, "R6 plain unexecuted");
    // R8: trap_done while running is ignored
    s = blank(); s.vld = 0; s.tdone = 1; drive(s, "R8 tdone running");
    // R7: fault
    s = blank(); s.ex = 1; s.flt = 1; s.pend = 1; drive(s, "R7 fault wait");
    s = blank(); s.ex = 1; s.flt = 1; s.st = 1; drive(s, "R7 trap");
    // R8: trap pending blocks all heads
    s = blank(); s.ex = 1; s.dv = 2'b01; drive(s, "R8 blocked retire");
    s = blank(); s.ns = 1; s.seq = 8'h80; drive(s, "R8 blocked nonspec");
    s = blank(); s.ex = 1; s.tdone = 1; drive(s, "R8 trap done");
    s = blank(); s.ex = 1; s.dv = 2'b01; s.da = {5'd0, 5'd31}; s.dp = {6'd0, 6'd63};
    drive(s, "R8 R1 resumed retire");
    s = blank(); s.vld = 0; drive(s, "R9 idle tail");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule